// File: doc/BRIEF.md
# Circular Receive Buffer Write Controller

This block owns the upper part of a 24 KB byte-addressed packet SRAM and fills it with received bytes. That part is used as a ring. Its lower bound is a start pointer that software programs. Its upper bound is fixed at the last memory address, 0x5FFF.

Each accepted byte becomes a write strobe, an address and a data byte, all in the same cycle. The write address then moves up by one. After the byte at the top address, the next byte goes to the start pointer. Memory below the start pointer is left to other users and is never written.

A small register port holds the start pointer and a receive-enable bit. The pointer accepts writes only while reception is off. When reception is switched on, the write address is reloaded from the pointer. The size of the ring is always available on an output.

Top module: `rx_ring_writer`

## Requirements
- R1: Every receive write (`mem_we` = 1) has `mem_addr` between `start_ptr` and 0x5FFF, both inclusive.
- R2: Accepted bytes go to consecutive ascending addresses: after a write at address A below 0x5FFF, `wr_ptr` is A+1.
- R3: After a write at 0x5FFF, the next write goes to `start_ptr`.
- R4: Bit 0 of `start_ptr` always reads 0, so the pointer is always even.
- R5: After reset, `start_ptr` and `wr_ptr` are 0x5340, `region_size` is 3264 (0x0CC0) and `rx_en` is 0.
- R6: `region_size` equals 0x6000 minus `start_ptr` at all times.
- R7: A pointer write that arrives while `rx_en` is 1 leaves `start_ptr` unchanged.
- R8: The write that switches `rx_en` from 0 to 1 loads `wr_ptr` with `start_ptr`. The new value is visible in the first cycle in which `rx_en` reads 1.
- R9: While `rx_en` is 0, a byte on `rx_valid` produces no `mem_we` and leaves `wr_ptr` unchanged.
- R10: A pointer write keeps only `reg_wdata[14:0]`. A value above 0x5FFE is replaced by 0x5FFE, and bit 0 is then cleared.
- R11: An accepted byte raises `mem_we` in the same cycle, with `mem_wdata` equal to `rx_data`. The write is never stalled.
- R12: Register select: `reg_sel` = 0 writes the start pointer, and `reg_sel` = 1 writes `rx_en` from `reg_wdata[0]`. Both take effect at the clock edge where `reg_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = start pointer, 1 = control |
| reg_wdata | input | 16 | Register write data |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| mem_we | output | 1 | SRAM write strobe |
| mem_addr | output | 15 | SRAM byte address |
| mem_wdata | output | 8 | SRAM write data |
| start_ptr | output | 15 | Current ring start pointer |
| rx_en | output | 1 | Receive enable |
| region_size | output | 16 | Ring size in bytes |
| wr_ptr | output | 15 | Next write address |

## Verification
Two things can happen in the same cycle: a wrap of the write address at 0x5FFF and a software attempt to move the start pointer. The bench sets up a 16-byte ring and streams bytes through it. On the exact cycle that writes 0x5FFF, it also issues a pointer write while reception is enabled. The collision passes if the following byte lands on the old start pointer and the pointer register keeps its value.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
   typedef enum logic {
      SEL_START = 1'b0,
      SEL_CTRL  = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/rx_ring_cfg.sv
module rx_ring_cfg
   import rx_ring_pkg::*;
#(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 16,
   parameter int TOP        = 'h5FFF,
   parameter int RST_START  = 'h5340,
   parameter int ALIGN_BITS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] start_ptr,
   output logic              rx_en,
   output logic              en_rise,
   output logic [ADDR_W:0]   region_size
);
   localparam int MAX_PTR = TOP + 1 - (2 ** ALIGN_BITS);
   localparam logic [ADDR_W-1:0] MAX_A  = ADDR_W'(MAX_PTR);
   localparam logic [ADDR_W:0]   SPAN_A = (ADDR_W + 1)'(TOP + 1);

   if (DATA_W < ADDR_W) begin : g_bad_data_w
      $error("rx_ring_cfg: DATA_W must cover ADDR_W");
   end
   if (RST_START % (2 ** ALIGN_BITS) != 0 || RST_START > MAX_PTR) begin : g_bad_rst
      $error("rx_ring_cfg: RST_START must be aligned and inside the ring");
   end

   logic [ADDR_W-1:0] masked, clamped, aligned;
   logic              unused_hi;

   assign unused_hi = ^reg_wdata[DATA_W-1:ADDR_W];
   assign masked    = reg_wdata[ADDR_W-1:0];
   assign clamped   = (masked > MAX_A) ? MAX_A : masked;

   if (ALIGN_BITS > 0) begin : g_align
      assign aligned = {clamped[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
   end else begin : g_noalign
      assign aligned = clamped;
   end

   logic ptr_wr, ctl_wr;
   assign ptr_wr  = reg_we && (reg_sel_e'(reg_sel) == SEL_START) && !rx_en;
   assign ctl_wr  = reg_we && (reg_sel_e'(reg_sel) == SEL_CTRL);
   assign en_rise = ctl_wr && reg_wdata[0] && !rx_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_ptr <= ADDR_W'(RST_START);
         rx_en     <= 1'b0;
      end else begin
         if (ptr_wr) start_ptr <= aligned;
         if (ctl_wr) rx_en     <= reg_wdata[0];
      end
   end

   assign region_size = SPAN_A - {1'b0, start_ptr};

   assert_start_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_ptr[0] == 1'b0 && start_ptr <= MAX_A);

   assert_ptr_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && reg_we && reg_sel == 1'b0) |=> $stable(start_ptr));

   assert_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ADDR_W + 1)'(region_size + {1'b0, start_ptr}) == SPAN_A);
endmodule

// File: rtl/rx_ring_addr.sv
module rx_ring_addr #(
   parameter int ADDR_W    = 15,
   parameter int TOP       = 'h5FFF,
   parameter int RST_START = 'h5340
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_rise,
   input  logic              accept,
   input  logic [ADDR_W-1:0] start_ptr,
   output logic [ADDR_W-1:0] wr_ptr
);
   localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(TOP);

   if (TOP >= 2 ** ADDR_W) begin : g_bad_top
      $error("rx_ring_addr: TOP does not fit in ADDR_W");
   end

   logic at_top;
   assign at_top = (wr_ptr == TOP_A);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= ADDR_W'(RST_START);
      end else if (en_rise) begin
         wr_ptr <= start_ptr;
      end else if (accept) begin
         wr_ptr <= at_top ? start_ptr : wr_ptr + 1'b1;
      end
   end

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && wr_ptr != TOP_A) |=> wr_ptr == $past(wr_ptr) + 1'b1);

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && wr_ptr == TOP_A) |=> wr_ptr == $past(start_ptr));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept && !en_rise) |=> $stable(wr_ptr));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 16,
   parameter int BYTE_W     = 8,
   parameter int TOP        = 'h5FFF,
   parameter int RST_START  = 'h5340,
   parameter int ALIGN_BITS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] start_ptr,
   output logic              rx_en,
   output logic [ADDR_W:0]   region_size,
   output logic [ADDR_W-1:0] wr_ptr
);
   localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(TOP);

   logic en_rise, accept;

   rx_ring_cfg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP(TOP),
      .RST_START(RST_START), .ALIGN_BITS(ALIGN_BITS)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .start_ptr(start_ptr), .rx_en(rx_en),
      .en_rise(en_rise), .region_size(region_size)
   );

   assign accept = rx_valid && rx_en;

   rx_ring_addr #(
      .ADDR_W(ADDR_W), .TOP(TOP), .RST_START(RST_START)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .en_rise(en_rise), .accept(accept),
      .start_ptr(start_ptr), .wr_ptr(wr_ptr)
   );

   assign mem_we    = accept;
   assign mem_addr  = wr_ptr;
   assign mem_wdata = rx_data;

   assert_in_ring_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr >= start_ptr && mem_addr <= TOP_A));

   assert_no_write_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> !mem_we);

   assert_no_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_en) |-> (mem_we && mem_wdata == rx_data));

   assert_enable_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_en) |-> wr_ptr == start_ptr);
endmodule

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_sel = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        mem_we;
   logic [14:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [14:0] start_ptr;
   logic        rx_en;
   logic [15:0] region_size;
   logic [14:0] wr_ptr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rx_ring_writer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .start_ptr(start_ptr), .rx_en(rx_en), .region_size(region_size),
      .wr_ptr(wr_ptr)
   );

   // {written value, expected pointer}
   localparam logic [31:0] VEC [0:7] = '{
      32'h0000_0000, 32'h1235_1234, 32'h5FFE_5FFE, 32'h5FFF_5FFE,
      32'h7FFF_5FFE, 32'h8100_0100, 32'h6000_5FFE, 32'h5FFC_5FFC
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic reg_write(input logic sel, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   initial begin
      logic [14:0] e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 start_ptr", 32'(start_ptr), 32'h5340);
      check("R5 wr_ptr", 32'(wr_ptr), 32'h5340);
      check("R5 region_size", 32'(region_size), 32'h0CC0);
      check("R5 rx_en", 32'(rx_en), 32'h0);
      check("R4 wr_ptr even", 32'(wr_ptr[0]), 32'h0);

      rx_valid = 1'b1; rx_data = 8'hA5; #1;
      check("R9 no write while off", 32'(mem_we), 32'h0);
      @(negedge clk); rx_valid = 1'b0;
      check("R9 wr_ptr held", 32'(wr_ptr), 32'h5340);

      for (int i = 0; i < 8; i++) begin
         reg_write(1'b0, VEC[i][31:16]);
         check("R10 clamp/mask", 32'(start_ptr), 32'(VEC[i][15:0]));
         check("R4 bit0", 32'(start_ptr[0]), 32'h0);
         check("R6 size", 32'(region_size), 32'h6000 - 32'(VEC[i][15:0]));
      end

      reg_write(1'b0, 16'h5FF0);
      check("R12 ptr sel", 32'(start_ptr), 32'h5FF0);
      check("R6 size 16", 32'(region_size), 32'd16);
      reg_write(1'b1, 16'h0001);
      check("R12 ctrl sel", 32'(rx_en), 32'h1);
      check("R8 load on enable", 32'(wr_ptr), 32'h5FF0);

      e = 15'h5FF0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = 8'(i * 7 + 3);
         if (e == 15'h5FFF) begin
            reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h1000;
         end else begin
            reg_we = 1'b0;
         end
         #1;
         check("R11 strobe", 32'(mem_we), 32'h1);
         check("R11 data", 32'(mem_wdata), 32'(i * 7 + 3) & 32'hFF);
         check("R2/R3 address", 32'(mem_addr), 32'(e));
         check("R1 in ring", 32'(mem_addr >= start_ptr), 32'h1);
         e = (e == 15'h5FFF) ? 15'h5FF0 : e + 1'b1;
      end
      @(negedge clk);
      rx_valid = 1'b0; reg_we = 1'b0;
      check("R7 ptr locked at wrap", 32'(start_ptr), 32'h5FF0);
      check("R2 final wr_ptr", 32'(wr_ptr), 32'h5FF4);

      reg_write(1'b0, 16'h0200);
      check("R7 ptr write ignored", 32'(start_ptr), 32'h5FF0);

      reg_write(1'b1, 16'h0000);
      rx_valid = 1'b1; #1;
      check("R9 no write after disable", 32'(mem_we), 32'h0);
      @(negedge clk); rx_valid = 1'b0;
      check("R9 wr_ptr kept", 32'(wr_ptr), 32'h5FF4);

      reg_write(1'b1, 16'h0001);
      check("R8 reload on re-enable", 32'(wr_ptr), 32'h5FF0);

      reg_write(1'b1, 16'h0000);
      reg_write(1'b0, 16'h0200);
      check("R7 ptr write while off", 32'(start_ptr), 32'h0200);
      check("R6 size", 32'(region_size), 32'h5E00);
      reg_write(1'b1, 16'h0001);
      rx_valid = 1'b1; rx_data = 8'h3C; #1;
      check("R1 first write at start", 32'(mem_addr), 32'h0200);
      @(negedge clk); rx_valid = 1'b0;
      check("R2 step", 32'(wr_ptr), 32'h0201);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule